// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block merges up to eight edge-sensitive event inputs into one active-high interrupt request and presents them to a host as a single register. A host write loads the enable mask; the register's read value is the set of enabled sources that have seen a rising edge since they were last enabled. Which source bits exist at all is fixed by a mask parameter; the other bits are absent.

There is no separate acknowledge path. The host acknowledges by writing a mask with the serviced bits cleared, which wipes their latches. It then writes the original mask back to re-arm them. Writing zero shuts off and clears every source, which is how the host quiesces the block at start-up and when an acquisition ends. The request output follows the status: it stays high while any status bit is set and falls once the status reads zero.

Top module: `irq_gate`

## Requirements
- R1: After reset the enable mask and the status read value (`rd_data`) are all zero and `irq` is low.
- R2: A write (`wr_en` high at a clock edge) loads `wr_data & VALID_MASK` as the enable mask. Bit positions that are 0 in `VALID_MASK` ignore writes and always read 0.
- R3: A source input is sampled at each clock edge. A rising edge is a sample of 1 after a sample of 0. If the source's enable bit is 1, the rising edge sets its status bit, which is visible on `rd_data` right after that same clock edge.
- R4: A source whose enable bit is 0 never sets its status bit. An input that is held high produces no further edges.
- R5: A write whose mask has a source's bit at 0 clears that source's status bit at the write's clock edge. Once the source is enabled again, a later rising edge latches it again.
- R6: A rising edge sampled at the same clock edge as a write that disables its source is discarded.
- R7: A rising edge sampled at the same clock edge as a write that enables its source is not latched, because the enable was still 0 at that edge.
- R8: `irq` is a registered output. It is high exactly while `rd_data` is non-zero, and it changes at the same clock edge as `rd_data`.
- R9: A latched status bit stays set after its input falls. It also stays set through writes that keep its enable bit at 1, until a write clears that enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the enable mask |
| wr_data | input | NSRC | Enable mask to load |
| src_in | input | NSRC | Event inputs, one per source |
| rd_data | output | NSRC | Latched status of the enabled sources |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
A wrong enable or edge-history bit shows up on `rd_data` at the first clock edge where an edge arrives on that source. The effect is either a missing latch or a spurious one. A status latch that fails to clear, or that clears on its own, is visible on `rd_data` and `irq` at the very next edge. A per-cycle reference model therefore exposes any divergence within one cycle of the stimulus that reveals it. The stimulus includes edges that coincide with enabling and disabling writes, held-high inputs, and writes to bits outside the valid mask.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] VALID_MASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_data,
  input  logic [NSRC-1:0] src_in,
  output logic [NSRC-1:0] rd_data,
  output logic            irq
);

  logic [NSRC-1:0] en_q, stat_q, prev_q;
  logic [NSRC-1:0] en_d, stat_d, rise;

  assign rise   = src_in & ~prev_q & VALID_MASK;
  assign en_d   = wr_en ? (wr_data & VALID_MASK) : en_q;
  assign stat_d = (stat_q | (rise & en_q)) & en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
      prev_q <= '0;
      irq    <= 1'b0;
    end else begin
      en_q   <= en_d;
      stat_q <= stat_d;
      prev_q <= src_in;
      irq    <= |stat_d;
    end
  end

  assign rd_data = stat_q;

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] VALID_MASK = '1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [NSRC-1:0] wr_data,
  input logic [NSRC-1:0] rd_data,
  input logic [NSRC-1:0] en_q,
  input logic            irq
);

  // R2
  invalid_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data | en_q) & ~VALID_MASK) == '0);

  // R4
  status_within_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~en_q) == '0);

  // R8
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data != '0));

  // R5
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data & ~$past(wr_data)) == '0);

  // R9
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_data & $past(rd_data)) == $past(rd_data));

endmodule

bind irq_gate irq_gate_chk #(.NSRC(NSRC), .VALID_MASK(VALID_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .en_q(en_q), .irq(irq)
);

// File: tb/irq_gate_tb.sv
module irq_gate_tb;
  localparam int NSRC = 8;
  localparam logic [7:0] VMASK = 8'h5F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] src_in = '0;
  logic [7:0] rd_data;
  logic irq;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  bit done = 1'b0;

  int m_en, m_stat, m_prev;
  bit m_irq;

  always #2.5 clk = ~clk;

  irq_gate #(.NSRC(NSRC), .VALID_MASK(VMASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .src_in(src_in), .rd_data(rd_data), .irq(irq)
  );

  task automatic compare(string tag);
    vectors++;
    if (rd_data !== m_stat[7:0] || irq !== m_irq) begin
      misses++;
      $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
               tag, rd_data, irq, m_stat[7:0], m_irq);
    end
  endtask

  task automatic step(bit w, logic [7:0] d, logic [7:0] s, string tag);
    int rise, en_n;
    @(negedge clk);
    wr_en = w; wr_data = d; src_in = s;
    @(posedge clk);
    rise   = int'(s) & ~m_prev & int'(VMASK);
    en_n   = w ? (int'(d) & int'(VMASK)) : m_en;
    m_stat = (m_stat | (rise & m_en)) & en_n;
    m_en   = en_n;
    m_prev = int'(s);
    m_irq  = (m_stat != 0);
    #1;
    compare(tag);
  endtask

  task automatic expect_val(logic [7:0] exp, string tag);
    vectors++;
    if (rd_data !== exp) begin
      misses++;
      $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, exp);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        misses++;
        $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end

  initial begin
    m_en = 0; m_stat = 0; m_prev = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    expect_val(8'h00, "R1 reset status");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 8'h00, 8'h00, "R1 idle");

    // R4: edges with nothing enabled
    step(0, 8'h00, 8'hFF, "R4 disabled edge");
    step(0, 8'h00, 8'h00, "R4 disabled edge");
    expect_val(8'h00, "R4 no latch");

    // R2: invalid bits ignored
    step(1, 8'hFF, 8'h00, "R2 mask load");
    step(0, 8'h00, 8'hFF, "R2 R3 all edges");
    expect_val(8'h5F, "R2 only valid bits latch");

    // R9: input falls, latch holds; rewrite keeping bits holds
    step(0, 8'h00, 8'h00, "R9 input falls");
    step(1, 8'hFF, 8'h00, "R9 rewrite same mask");
    expect_val(8'h5F, "R9 latch held");

    // R5: acknowledge bit 0 by dropping and restoring
    step(1, 8'hFE, 8'h00, "R5 drop bit0");
    expect_val(8'h5E, "R5 bit0 cleared");
    step(1, 8'hFF, 8'h00, "R5 restore");
    step(0, 8'h00, 8'h01, "R5 relatch");
    expect_val(8'h5F, "R5 bit0 relatched");

    // R8: clear all, irq falls
    step(1, 8'h00, 8'h00, "R8 clear all");
    expect_val(8'h00, "R8 status zero");
    step(1, 8'h03, 8'h00, "R3 enable two");
    step(0, 8'h00, 8'h02, "R3 edge bit1");
    expect_val(8'h02, "R3 bit1 latched");
    step(0, 8'h00, 8'h02, "R4 held high no relatch");
    step(1, 8'h01, 8'h02, "R5 clear bit1");
    step(1, 8'h03, 8'h02, "R4 re-enable while held high");
    expect_val(8'h00, "R4 held level is not an edge");

    // R6: edge with disabling write
    step(0, 8'h00, 8'h00, "R6 prep");
    step(1, 8'h02, 8'h01, "R6 edge and disable");
    expect_val(8'h00, "R6 discarded");
    step(1, 8'h03, 8'h00, "R6 re-enable");

    // R7: edge with enabling write
    step(1, 8'h00, 8'h00, "R7 prep");
    step(1, 8'h04, 8'h04, "R7 edge and enable");
    expect_val(8'h00, "R7 not latched");
    step(0, 8'h00, 8'h00, "R7 fall");
    step(0, 8'h00, 8'h04, "R7 later edge");
    expect_val(8'h04, "R7 later edge latched");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit w;
      w = ($urandom_range(0, 5) == 0);
      step(w, 8'($urandom), 8'($urandom), "R3 R5 R8 mixed");
    end

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    m_en = 0; m_stat = 0; m_prev = 0; m_irq = 0;
    #1;
    compare("R1 async reset");
    @(negedge clk);
    wr_en = 0; src_in = 0;
    rst_n = 1'b1;
    step(0, 8'h00, 8'h00, "R1 after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule